// File: doc/BRIEF.md
# APB Requester Transfer Controller

This block turns single commands from a local requester into transfers on an APB bus. The requester offers an address, a direction flag and write data with a valid/ready handshake. The controller then runs a one-cycle setup phase followed by an access phase. The access phase lasts as long as the selected completer keeps pready low. When the transfer completes, the controller returns the read data and the completer's error flag on a response strobe that is one cycle wide.

Only one command is in flight at a time. The command interface is ready only while the controller is idle. After every transfer the bus goes idle for at least one cycle, and that idle cycle is also when the next command can be taken. Because the command fields are registered when the handshake happens, the requester may change them freely once its command has been accepted.

Top module: `apb_req_ctrl`

## Requirements
- R1: While rst_ni is low and after it is released, psel_o, penable_o and rsp_valid_o are low and cmd_ready_o is high.
- R2: cmd_ready_o is high exactly when no transfer is in progress (psel_o low). A command is taken at a rising clock edge where cmd_valid_i and cmd_ready_o are both high, and its setup phase starts in the next cycle. Command inputs that change after that edge do not affect the transfer.
- R3: The setup phase lasts exactly one cycle, with psel_o=1 and penable_o=0. During it, paddr_o carries the command address and pwrite_o carries the write flag (1 = write, 0 = read). For writes, pwdata_o carries the command write data.
- R4: The access phase starts in the cycle after setup, with psel_o=1 and penable_o=1. It lasts while pready_i is low, and during that time paddr_o, pwrite_o and pwdata_o hold their values.
- R5: A transfer completes only in a cycle where penable_o and pready_i are both high. pready_i is ignored in the idle and setup cycles. With pready_i high in the first access cycle, psel_o is high for exactly two cycles.
- R6: rsp_valid_o is high for exactly the one cycle after the completing edge. For a read, rsp_rdata_o then equals the prdata_i value sampled in the completing cycle. prdata_i values seen in wait cycles are discarded.
- R7: rsp_err_o, which is valid with rsp_valid_o, equals the pslverr_i value sampled in the completing cycle, for both reads and writes.
- R8: After completion, psel_o and penable_o are both low in the following cycle, and cmd_ready_o is high so that the next command can be taken in that cycle.
- R9: While cmd_valid_i stays low in idle, psel_o stays low and no transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for all logic and for the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | A command is offered |
| cmd_ready_o | output | 1 | Controller can take a command |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_addr_i | input | ADDR_W | Command address |
| cmd_wdata_i | input | DATA_W | Command write data |
| rsp_valid_o | output | 1 | Response strobe, one cycle wide |
| rsp_rdata_o | output | DATA_W | Read data of the last completed read |
| rsp_err_o | output | 1 | Error flag of the completed transfer |
| psel_o | output | 1 | Bus select |
| penable_o | output | 1 | Access phase indicator |
| pwrite_o | output | 1 | Bus direction |
| paddr_o | output | ADDR_W | Bus address |
| pwdata_o | output | DATA_W | Bus write data |
| pready_i | input | 1 | Completer ready |
| prdata_i | input | DATA_W | Completer read data |
| pslverr_i | input | 1 | Completer error |

## Verification
The bench builds the controller with ADDR_W=12 and DATA_W=16. These narrower buses let random addresses and data reach the top bits often, so a truncated or misrouted field shows up. With random wait counts from zero to four, plus directed long waits of twenty cycles, the bench covers zero-wait transfers, extended access phases and random pready, prdata and pslverr noise in cycles that must be ignored. Directed cases check the reset state, an idle bus with no command, and error flags on both reads and writes.

// File: rtl/apb_req_pkg.sv
package apb_req_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/apb_req_seq.sv
module apb_req_seq
  import apb_req_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_valid_i,
  input  logic pready_i,
  output logic idle_o,
  output logic load_o,
  output logic sel_o,
  output logic enable_o,
  output logic done_o
);
  xfer_state_e state_q, state_d;

  assign idle_o   = (state_q == ST_IDLE);
  assign sel_o    = (state_q != ST_IDLE);
  assign enable_o = (state_q == ST_ACCESS);
  assign load_o   = idle_o && cmd_valid_i;
  assign done_o   = enable_o && pready_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (cmd_valid_i) state_d = ST_SETUP;
      ST_SETUP:  state_d = ST_ACCESS;
      ST_ACCESS: if (pready_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // R3
  setup_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o && !enable_o) |=> (sel_o && enable_o));
  // R5
  access_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_o && !pready_i) |=> enable_o);
  // R8
  idle_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!sel_o && !enable_o));
  // R4
  enable_needs_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_o |-> sel_o);
endmodule

// File: rtl/apb_req_hold.sv
module apb_req_hold #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              stall_i,
  output logic              write_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      write_o <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (load_i) begin
      write_o <= write_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end

  // R4
  req_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && stall_i) |=> ($stable(addr_o) && $stable(write_o) && $stable(wdata_o)));
endmodule

// File: rtl/apb_req_rsp.sv
module apb_req_rsp #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] prdata_i,
  input  logic              pslverr_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= done_i;
      if (done_i) begin
        err_o <= pslverr_i;
        if (!write_i) rdata_o <= prdata_i;
      end
    end
  end

  // R6
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R7
  rsp_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (valid_o && err_o == $past(pslverr_i)));
endmodule

// File: rtl/apb_req_ctrl.sv
module apb_req_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_write_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_err_o,
  output logic              psel_o,
  output logic              penable_o,
  output logic              pwrite_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic [DATA_W-1:0] pwdata_o,
  input  logic              pready_i,
  input  logic [DATA_W-1:0] prdata_i,
  input  logic              pslverr_i
);
  logic idle, load, done;

  apb_req_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .pready_i    (pready_i),
    .idle_o      (idle),
    .load_o      (load),
    .sel_o       (psel_o),
    .enable_o    (penable_o),
    .done_o      (done)
  );

  apb_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .write_i (cmd_write_i),
    .addr_i  (cmd_addr_i),
    .wdata_i (cmd_wdata_i),
    .busy_i  (penable_o),
    .stall_i (!pready_i),
    .write_o (pwrite_o),
    .addr_o  (paddr_o),
    .wdata_o (pwdata_o)
  );

  apb_req_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (done),
    .write_i   (pwrite_o),
    .prdata_i  (prdata_i),
    .pslverr_i (pslverr_i),
    .valid_o   (rsp_valid_o),
    .rdata_o   (rsp_rdata_o),
    .err_o     (rsp_err_o)
  );

  assign cmd_ready_o = idle;

  // R2
  ready_only_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !psel_o);
  // R2
  accept_to_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> (psel_o && !penable_o && paddr_o == $past(cmd_addr_i)));
  // R3
  sel_rise_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(psel_o) |-> !penable_o);
  // R9
  no_cmd_stay_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_ready_o && !cmd_valid_i) |=> !psel_o);
endmodule

// File: tb/apb_req_ctrl_test.sv
`timescale 1ns/1ps
module apb_req_ctrl_test;
  localparam int AW = 12;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic cmd_ready, rsp_valid, rsp_err, psel, penable, pwrite;
  logic [DW-1:0] rsp_rdata, pwdata;
  logic [AW-1:0] paddr;
  logic pready = 1'b0, pslverr = 1'b0;
  logic [DW-1:0] prdata = '0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  apb_req_ctrl #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_write_i(cmd_write),
    .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
    .psel_o(psel), .penable_o(penable), .pwrite_o(pwrite),
    .paddr_o(paddr), .pwdata_o(pwdata),
    .pready_i(pready), .prdata_i(prdata), .pslverr_i(pslverr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected read response: data seen in the completing cycle
  function automatic logic [31:0] exp_rdata(logic [DW-1:0] last_rd);
    return 32'(last_rd);
  endfunction

  // expected cycles with psel high for a transfer with n wait states
  function automatic int exp_sel_cycles(int waits);
    return waits + 2;
  endfunction

  logic [DW-1:0] last_rd = '0;

  task automatic xfer(bit w, logic [AW-1:0] a, logic [DW-1:0] wd,
                      int waits, logic [DW-1:0] rd, bit err);
    int sel_cnt = 0;
    @(negedge clk);
    chk("R2 ready in idle", 32'(cmd_ready), 1);
    chk("R6 strobe single", 32'(rsp_valid), 0);
    cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_wdata = wd;
    pready = 1'($urandom);
    @(negedge clk);
    sel_cnt += int'(psel);
    chk("R3 setup psel", 32'(psel), 1);
    chk("R3 setup penable", 32'(penable), 0);
    chk("R3 setup paddr", 32'(paddr), 32'(a));
    chk("R3 setup pwrite", 32'(pwrite), 32'(w));
    if (w) chk("R3 setup pwdata", 32'(pwdata), 32'(wd));
    chk("R2 not ready busy", 32'(cmd_ready), 0);
    cmd_valid = 1'b0; cmd_write = 1'($urandom);
    cmd_addr = AW'($urandom); cmd_wdata = DW'($urandom);
    pready = 1'($urandom);  // R5: ignored in setup
    for (int i = 0; i <= waits; i++) begin
      @(negedge clk);
      sel_cnt += int'(psel);
      chk("R4 access penable", 32'(penable), 1);
      chk("R4 paddr stable", 32'(paddr), 32'(a));
      chk("R4 pwrite stable", 32'(pwrite), 32'(w));
      if (w) chk("R4 pwdata stable", 32'(pwdata), 32'(wd));
      chk("R6 no early rsp", 32'(rsp_valid), 0);
      pready  = (i == waits);
      prdata  = (i == waits) ? rd : DW'($urandom);
      pslverr = (i == waits) ? err : 1'($urandom);
    end
    if (!w) last_rd = rd;
    @(negedge clk);
    chk("R5 psel cycles", 32'(sel_cnt), 32'(exp_sel_cycles(waits)));
    chk("R6 rsp strobe", 32'(rsp_valid), 1);
    chk("R6 rsp rdata", 32'(rsp_rdata), exp_rdata(last_rd));
    chk("R7 rsp err", 32'(rsp_err), 32'(err));
    chk("R8 psel low", 32'(psel), 0);
    chk("R8 penable low", 32'(penable), 0);
    chk("R8 ready again", 32'(cmd_ready), 1);
    pready = 1'($urandom); prdata = DW'($urandom); pslverr = 1'($urandom);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 psel", 32'(psel), 0);
    chk("R1 penable", 32'(penable), 0);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 cmd_ready", 32'(cmd_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 psel after", 32'(psel), 0);
    chk("R1 ready after", 32'(cmd_ready), 1);
    // R9 idle bus with noise on completer side
    for (int i = 0; i < 6; i++) begin
      pready = 1'($urandom); prdata = DW'($urandom);
      @(negedge clk);
      chk("R9 stay idle", 32'(psel), 0);
    end
    // directed corners
    xfer(1'b1, 12'hFFF, 16'hFFFF, 0, 16'h0000, 1'b0);
    xfer(1'b0, 12'h800, 16'h0000, 0, 16'hA5C3, 1'b1);
    xfer(1'b1, 12'h001, 16'h8001, 20, 16'h0000, 1'b1);  // R7 err on write
    xfer(1'b0, 12'h7FE, 16'h1234, 20, 16'hFFFF, 1'b0);
    xfer(1'b0, 12'h000, 16'h0000, 1, 16'h0000, 1'b1);
    // random mix
    for (int k = 0; k < 300; k++) begin
      xfer(1'($urandom), AW'($urandom), DW'($urandom), int'($urandom_range(0, 4)),
           DW'($urandom), 1'($urandom));
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule